// File: doc/BRIEF.md
# Masked Priority Interrupt Resolver

This block collects eight interrupt request lines, records them in a request register and arbitrates among them with a fixed priority in which line 0 is the most urgent. A per-line mask gates the recorded requests before arbitration. When an unmasked pending request is more urgent than every level currently in service, the interrupt output to the processor goes high.

The processor answers with a sequence of acknowledge pulses. On the first pulse of a sequence, the winning request moves into the in-service register, its request bit is cleared and its level number is presented on a level output. An in-service bit is released in one of two ways: automatically on the last pulse of the sequence, or later by an end-of-interrupt command written by software. That command either clears the most urgent in-service level or clears a level that the command names.

A small register port with chip select, write strobe, read strobe and one address bit is used to load the mask and issue commands. The same port reads back the request, in-service or mask register, whichever a prior command selected.

Top module: `pir_resolver`

## Requirements
- R1: After reset the mask register reads 0xFF, the request and in-service registers read 0x00, `int_o` is low, and the block is in level mode with automatic release off.
- R2: In level mode, a request bit follows its input line after a two-flop synchroniser, so it is visible on the third rising clock edge after the line changes.
- R3: In edge mode (configuration bit 1), a rising edge on a line sets its request bit, and the bit stays set after the line falls until an acknowledge takes it. A line held high after that acknowledge raises no new request.
- R4: A mask bit set to 1 (address 1 write, bit n for line n) stops line n from raising `int_o` or winning arbitration. The request bit is still recorded, and a less urgent unmasked line is served as if the masked one were absent.
- R5: Among eligible requests, the lowest line number wins.
- R6: On the first acknowledge pulse of a sequence, the winning line's in-service bit is set, its request bit is cleared and `ack_level_o` takes the winner's number. No in-service bit is set at any other time.
- R7: `int_o` is high only while some unmasked pending line has a lower number than every set in-service bit. A pending line at or below the priority of an in-service level does not raise it.
- R8: With automatic release on (configuration bit 0), the in-service bit of the sequence's winner is cleared on the last acknowledge pulse of the sequence. With the default of two pulses, that is the second pulse.
- R9: With automatic release off, an in-service bit stays set until an end-of-interrupt command. The non-specific form (command byte 0b01xxxxxx at address 0) clears the lowest-numbered set in-service bit.
- R10: The specific end-of-interrupt form (command byte 0b10xxxLLL at address 0) clears the in-service bit for level LLL.
- R11: A read (cs_n and rd_n low) returns the register chosen by the last select command (byte 0b000000SS at address 0): SS=00 request, 01 in-service, 10 mask. When no read is active, `rdata_o` is 0x00. Configuration is written as byte 0b110000EA at address 0, with A as automatic release and E as edge mode.
- R12: A first acknowledge pulse with no eligible request returns level 7 on `ack_level_o` and changes no in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 8 | Asynchronous interrupt request lines, bit 0 most urgent |
| cs_n | input | 1 | Register port select, active low |
| wr_n | input | 1 | Write strobe, active low, one clock per write |
| rd_n | input | 1 | Read strobe, active low |
| addr_i | input | 1 | 0 selects the command byte, 1 selects the mask |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register |
| ack_i | input | 1 | Acknowledge pulse, one clock per pulse |
| int_o | output | 1 | Interrupt request to the processor |
| ack_level_o | output | 3 | Level granted by the last first-pulse acknowledge |

## Verification
The bench first masks a more urgent line and checks that a less urgent line still wins. A design that masked everything below the blocked line would stay silent here. It also confirms that a pending line at the same level as the one in service keeps `int_o` low, which a design comparing with the wrong inequality would raise. Right after an acknowledge, while the line is still high, the bench reads the request register to see the cleared bit. It checks that an edge-mode line held high does not request a second time, and that automatic release happens on the last pulse and not the first. Finally, it issues an acknowledge with nothing pending; a design that lacked the spurious path would disturb in-service bit 7 or report a stale level.

// File: rtl/pir_pkg.sv
package pir_pkg;

    // register chosen for read-back
    typedef enum logic [1:0] {
        SEL_REQ  = 2'b00,
        SEL_INSV = 2'b01,
        SEL_MASK = 2'b10
    } rsel_e;

    // command class held in bits [7:6] of an address-0 write
    typedef enum logic [1:0] {
        OP_RDSEL  = 2'b00,
        OP_EOI_NS = 2'b01,
        OP_EOI_SP = 2'b10,
        OP_CFG    = 2'b11
    } op_e;

    // decoded strobes of one register-port write
    typedef struct packed {
        logic  sel_wr;
        rsel_e sel;
        logic  eoi_ns;
        logic  eoi_sp;
        logic  cfg_wr;
        logic  cfg_auto;
        logic  cfg_edge;
        logic  mask_wr;
    } cmd_t;

endpackage

// File: rtl/pir_sync.sv
module pir_sync #(
    parameter int N      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] pipe_d [STAGES];
    logic [N-1:0] pipe_q [STAGES];
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        pipe_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
        prev_d = pipe_q[STAGES-1];
    end

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[s] <= '0;
                else        pipe_q[s] <= pipe_d[s];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign lvl_o  = pipe_q[STAGES-1];
    assign rise_o = pipe_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/pir_prio_enc.sv
module pir_prio_enc #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    // lowest set index wins
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
        found_o = |vec_i;
    end

endmodule

// File: rtl/pir_cmd_dec.sv
module pir_cmd_dec
    import pir_pkg::*;
#(
    parameter int DW    = 8,
    parameter int LVL_W = 3
) (
    input  logic             wr_stb_i,
    input  logic             addr_i,
    input  logic [DW-1:0]    wdata_i,
    output cmd_t             cmd_o,
    output logic [LVL_W-1:0] lvl_o
);
    op_e op;

    always_comb begin
        op    = op_e'(wdata_i[DW-1:DW-2]);
        cmd_o = '0;
        cmd_o.sel = SEL_REQ;
        lvl_o = wdata_i[LVL_W-1:0];
        if (wr_stb_i) begin
            if (addr_i) begin
                cmd_o.mask_wr = 1'b1;
            end else begin
                unique case (op)
                    OP_RDSEL: begin
                        cmd_o.sel_wr = 1'b1;
                        unique case (wdata_i[1:0])
                            2'b01:   cmd_o.sel = SEL_INSV;
                            2'b10:   cmd_o.sel = SEL_MASK;
                            default: cmd_o.sel = SEL_REQ;
                        endcase
                    end
                    OP_EOI_NS: cmd_o.eoi_ns = 1'b1;
                    OP_EOI_SP: cmd_o.eoi_sp = 1'b1;
                    OP_CFG: begin
                        cmd_o.cfg_wr   = 1'b1;
                        cmd_o.cfg_auto = wdata_i[0];
                        cmd_o.cfg_edge = wdata_i[1];
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/pir_resolver.sv
module pir_resolver
    import pir_pkg::*;
#(
    parameter int NUM_IRQ     = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ACK_PULSES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         irq_i,
    input  logic               cs_n,
    input  logic               wr_n,
    input  logic               rd_n,
    input  logic               addr_i,
    input  logic [7:0]         wdata_i,
    output logic [7:0]         rdata_o,
    input  logic               ack_i,
    output logic               int_o,
    output logic [2:0]         ack_level_o
);
    localparam int LVL_W = $clog2(NUM_IRQ);
    localparam int CNT_W = $clog2(ACK_PULSES + 1);
    localparam logic [LVL_W-1:0] SPUR_LVL = LVL_W'(NUM_IRQ - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ACK_PULSES - 1);

    typedef struct packed {
        logic [NUM_IRQ-1:0] irr;
        logic [NUM_IRQ-1:0] isr;
        logic [NUM_IRQ-1:0] mask;
        rsel_e              rsel;
        logic               auto_eoi;
        logic               edge_mode;
        logic [CNT_W-1:0]   ack_cnt;
        logic [LVL_W-1:0]   ack_lvl;
        logic               ack_real;
    } state_t;

    state_t st_d, st_q;

    // ---------------- sub-blocks ----------------
    logic [NUM_IRQ-1:0] line_lvl, line_rise;

    pir_sync #(.N(NUM_IRQ), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_i    (irq_i),
        .lvl_o  (line_lvl),
        .rise_o (line_rise)
    );

    logic               wr_stb;
    cmd_t               cmd;
    logic [LVL_W-1:0]   cmd_lvl;

    assign wr_stb = !cs_n && !wr_n;

    pir_cmd_dec #(.DW(NUM_IRQ), .LVL_W(LVL_W)) u_dec (
        .wr_stb_i (wr_stb),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .cmd_o    (cmd),
        .lvl_o    (cmd_lvl)
    );

    logic [NUM_IRQ-1:0] pend_vec;
    logic               pend_found, isr_found;
    logic [LVL_W-1:0]   pend_idx, isr_idx;

    assign pend_vec = st_q.irr & ~st_q.mask;

    pir_prio_enc #(.N(NUM_IRQ)) u_pend_enc (
        .vec_i   (pend_vec),
        .found_o (pend_found),
        .idx_o   (pend_idx)
    );

    pir_prio_enc #(.N(NUM_IRQ)) u_isr_enc (
        .vec_i   (st_q.isr),
        .found_o (isr_found),
        .idx_o   (isr_idx)
    );

    // ---------------- arbitration and next state ----------------
    logic               eligible;
    logic               ack_first, ack_last, take;
    logic [LVL_W-1:0]   grant_lvl, cur_lvl;
    logic               cur_real;
    logic [NUM_IRQ-1:0] ack_clr, isr_n;

    assign eligible = pend_found && (!isr_found || (pend_idx < isr_idx));

    always_comb begin
        st_d = st_q;

        ack_first = ack_i && (st_q.ack_cnt == '0);
        ack_last  = ack_i && (st_q.ack_cnt == LAST_CNT);
        take      = ack_first && eligible;
        grant_lvl = take ? pend_idx : SPUR_LVL;
        cur_lvl   = ack_first ? grant_lvl : st_q.ack_lvl;
        cur_real  = ack_first ? take : st_q.ack_real;

        ack_clr = '0;
        if (take) ack_clr[pend_idx] = 1'b1;

        // request register: a new edge outranks a same-cycle clear
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (st_q.edge_mode)
                st_d.irr[i] = (st_q.irr[i] & ~ack_clr[i]) | line_rise[i];
            else
                st_d.irr[i] = line_lvl[i] & ~ack_clr[i];
        end

        // in-service: commands first, then grant, then automatic release
        isr_n = st_q.isr;
        if (cmd.eoi_ns && isr_found) isr_n[isr_idx] = 1'b0;
        if (cmd.eoi_sp)              isr_n[cmd_lvl] = 1'b0;
        if (take)                    isr_n[pend_idx] = 1'b1;
        if (ack_last && st_q.auto_eoi && cur_real) isr_n[cur_lvl] = 1'b0;
        st_d.isr = isr_n;

        // acknowledge sequence bookkeeping
        if (ack_i) begin
            st_d.ack_cnt  = ack_last ? '0 : st_q.ack_cnt + CNT_W'(1);
            st_d.ack_lvl  = cur_lvl;
            st_d.ack_real = cur_real;
        end

        // register-port writes
        if (cmd.mask_wr) st_d.mask = wdata_i[NUM_IRQ-1:0];
        if (cmd.sel_wr)  st_d.rsel = cmd.sel;
        if (cmd.cfg_wr) begin
            st_d.auto_eoi  = cmd.cfg_auto;
            st_d.edge_mode = cmd.cfg_edge;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.mask      <= '1;
            st_q.rsel      <= SEL_REQ;
            st_q.ack_lvl   <= SPUR_LVL;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        rdata_o = '0;
        if (!cs_n && !rd_n) begin
            unique case (st_q.rsel)
                SEL_INSV: rdata_o = st_q.isr;
                SEL_MASK: rdata_o = st_q.mask;
                default:  rdata_o = st_q.irr;
            endcase
        end
    end

    assign int_o       = eligible;
    assign ack_level_o = st_q.ack_lvl;

    // ---------------- assertions ----------------
    // in-service bits appear only after an acknowledge pulse
    p_isr_only_on_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.isr & ~$past(st_q.isr)) != '0) |-> $past(ack_i));

    // at most one in-service bit is added at a time
    p_isr_single_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.isr & ~$past(st_q.isr)));

    // a masked line is never granted
    p_mask_no_win_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_first |=> ((st_q.isr & ~$past(st_q.isr) & $past(st_q.mask)) == '0));

    // edge-mode requests are only dropped by an acknowledge
    p_edge_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.edge_mode && !ack_i && !wr_stb) |=> ((~st_q.irr & $past(st_q.irr)) == '0));

    // automatic release on the last pulse
    p_auto_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_last && st_q.auto_eoi && cur_real) |=> !st_q.isr[$past(cur_lvl)]);

    // specific end-of-interrupt clears the named level
    p_spec_eoi_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.eoi_sp && !ack_i) |=> !st_q.isr[$past(cmd_lvl)]);

    // spurious first pulse reports the lowest-priority level
    p_spurious_lvl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_first && !eligible) |=> (ack_level_o == 3'(SPUR_LVL)));

endmodule

// File: tb/pir_resolver_bench.sv
module pir_resolver_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq = '0;
    logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ack = 1'b0;
    logic       intr;
    logic [2:0] lvl;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pir_resolver u_pir_resolver (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .cs_n(cs_n), .wr_n(wr_n),
        .rd_n(rd_n), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .ack_i(ack), .int_o(intr), .ack_level_o(lvl)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1; addr = 1'b0; wdata = '0;
    endtask

    task automatic sel(input logic [1:0] s);
        wr(1'b0, {6'b0, s});
    endtask

    task automatic peek(output logic [7:0] v);
        cs_n = 1'b0; rd_n = 1'b0;
        #0.5;
        v = rdata;
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic pulse_ack;
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic settle;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R1", "int after reset", {7'b0, intr}, 8'h00);
        peek(v); check("R1", "request after reset", v, 8'h00);
        sel(2'b01); peek(v); check("R1", "in-service after reset", v, 8'h00);
        sel(2'b10); peek(v); check("R11", "mask read after reset", v, 8'hFF);
        cs_n = 1'b1; #0.5; check("R11", "idle read data", rdata, 8'h00);
    endtask

    task automatic t_level_priority;
        logic [7:0] v;
        wr(1'b1, 8'h00);
        irq = 8'h28;
        @(negedge clk); @(negedge clk);
        check("R2", "int before sync latency", {7'b0, intr}, 8'h00);
        @(negedge clk);
        sel(2'b00); peek(v); check("R2", "request register", v, 8'h28);
        check("R7", "int with pending", {7'b0, intr}, 8'h01);
        pulse_ack;
        check("R5", "granted level", {5'b0, lvl}, 8'h03);
        peek(v); check("R6", "request bit cleared at grant", v, 8'h20);
        sel(2'b01); peek(v); check("R6", "in-service set", v, 8'h08);
        pulse_ack;
        check("R7", "int with same level in service", {7'b0, intr}, 8'h00);
        peek(v); check("R9", "in-service held without command", v, 8'h08);
        wr(1'b0, 8'h40);
        peek(v); check("R9", "non-specific release", v, 8'h00);
        check("R7", "int after release", {7'b0, intr}, 8'h01);
        irq = 8'h00; settle;
        check("R2", "int after lines drop", {7'b0, intr}, 8'h00);
    endtask

    task automatic t_nesting;
        logic [7:0] v;
        irq = 8'h20; settle;
        pulse_ack;
        check("R6", "nest outer level", {5'b0, lvl}, 8'h05);
        pulse_ack;
        irq = 8'h24; settle;
        check("R7", "more urgent line interrupts", {7'b0, intr}, 8'h01);
        pulse_ack;
        check("R6", "nest inner level", {5'b0, lvl}, 8'h02);
        pulse_ack;
        sel(2'b01); peek(v); check("R6", "both levels in service", v, 8'h24);
        wr(1'b0, 8'h40);
        peek(v); check("R9", "non-specific clears most urgent", v, 8'h20);
        wr(1'b0, 8'h85);
        peek(v); check("R10", "specific clears level 5", v, 8'h00);
        irq = 8'h00; settle;
    endtask

    task automatic t_mask;
        logic [7:0] v;
        wr(1'b1, 8'h02);
        irq = 8'h06; settle;
        check("R4", "lower line unblocked", {7'b0, intr}, 8'h01);
        pulse_ack;
        check("R4", "masked line skipped", {5'b0, lvl}, 8'h02);
        pulse_ack;
        wr(1'b0, 8'h40);
        wr(1'b1, 8'hFF);
        check("R4", "all masked no int", {7'b0, intr}, 8'h00);
        sel(2'b00); peek(v); check("R4", "masked requests recorded", v, 8'h06);
        sel(2'b10); peek(v); check("R11", "mask read back", v, 8'hFF);
        irq = 8'h00;
        wr(1'b1, 8'h00);
        settle;
    endtask

    task automatic t_edge_auto;
        logic [7:0] v;
        wr(1'b0, 8'hC3);
        sel(2'b00);
        irq = 8'h40; @(negedge clk); @(negedge clk);
        irq = 8'h00; settle;
        peek(v); check("R3", "edge request held after line low", v, 8'h40);
        check("R3", "edge int", {7'b0, intr}, 8'h01);
        sel(2'b01);
        pulse_ack;
        check("R6", "edge grant level", {5'b0, lvl}, 8'h06);
        peek(v); check("R8", "in-service held until last pulse", v, 8'h40);
        pulse_ack;
        peek(v); check("R8", "automatic release", v, 8'h00);
        irq = 8'h10; settle;
        check("R3", "held line requests", {7'b0, intr}, 8'h01);
        pulse_ack; pulse_ack;
        repeat (3) @(negedge clk);
        check("R3", "held line no repeat", {7'b0, intr}, 8'h00);
        irq = 8'h00; settle;
    endtask

    task automatic t_spurious;
        logic [7:0] v;
        wr(1'b0, 8'hC0);
        sel(2'b01); settle;
        pulse_ack;
        check("R12", "spurious level", {5'b0, lvl}, 8'h07);
        peek(v); check("R12", "no in-service change", v, 8'h00);
        pulse_ack;
        peek(v); check("R12", "no in-service after sequence", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_level_priority;
        t_nesting;
        t_mask;
        t_edge_auto;
        t_spurious;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule